// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits on the receive path of an Ethernet MAC. It decides whether an incoming frame should be kept, using only the frame's 48-bit destination address. The address arrives one byte per accepted beat, starting with the byte sent first on the wire. The block folds the address into a 6-bit index and uses that index to select one bit of a 64-bit table that the host programs. The selected bit is then qualified by the frame type: unicast or multicast, as set by the group bit. Each frame type has its own enable.

A copy-all setting accepts every frame whatever the table holds. The decision appears in the cycle after the sixth address byte is taken. It stays stable until the next frame-start strobe. A multicast flag goes with the decision so that the receive status can record it.

Software programs the table as two 32-bit words. It writes all ones together with the multicast enable to take in every multicast frame.

Top module: `dst_hash_filter`

## Requirements
- R1: While reset is asserted and after it is released, `decision_valid`, `accept` and `multicast_flag` are 0 and every table bit is 0.
- R2: Address bit j is bit (j mod 8) of byte (j div 8). Byte 0 is the first byte taken, and bit 0 is its least significant bit. Index bit n (n = 0..5) is the XOR of the eight address bits n, n+6, ..., n+42. For example, address bytes 00 01 00 00 00 00 give index 4, and 7E 00 00 00 00 00 give index 63.
- R3: A write with `tbl_lo_we` loads table bits 31:0 from `tbl_wdata`, and a write with `tbl_hi_we` loads bits 63:32. The other half is left untouched. A write in the same cycle as the sixth byte does not affect that frame's decision.
- R4: When address bit 0 is 1 and copy-all is off, `accept` equals `mcast_en` AND the indexed table bit.
- R5: When address bit 0 is 0 and copy-all is off, `accept` equals `ucast_en` AND the indexed table bit.
- R6: With `copy_all` high in the cycle of the sixth byte, `accept` is 1 regardless of the table and the enables.
- R7: `decision_valid` rises in the cycle after the sixth byte is taken. It holds until the next `frame_start`. Cycles with `byte_valid` low are skipped. Bytes after the sixth are ignored.
- R8: `frame_start` discards any partial address and clears `decision_valid` and `accept`. A byte presented in the same cycle as `frame_start` is taken as byte 0.
- R9: `multicast_flag` takes address bit 0 in the cycle after byte 0. It is cleared by a `frame_start` that carries no byte.
- R10: Once valid, the decision is not changed by later changes to the table, the enables or `copy_all`.
- R11: With all 64 table bits set and `mcast_en` high, every multicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Start-of-frame strobe; restarts address collection |
| byte_valid | input | 1 | `byte_data` carries an address byte this cycle |
| byte_data | input | 8 | Destination address byte, first-received byte first |
| tbl_lo_we | input | 1 | Write table bits 31:0 |
| tbl_hi_we | input | 1 | Write table bits 63:32 |
| tbl_wdata | input | 32 | Table write data |
| ucast_en | input | 1 | Enable hash matching of unicast frames |
| mcast_en | input | 1 | Enable hash matching of multicast frames |
| copy_all | input | 1 | Accept every frame |
| decision_valid | output | 1 | The decision for the current frame is available |
| accept | output | 1 | Keep the frame |
| multicast_flag | output | 1 | Group bit of the current address |

## Verification
The assertions check several rules on every cycle:
- the decision follows the sixth byte by exactly one cycle;
- a bare frame start clears it;
- a valid decision and its flag hold still until the next frame start;
- `accept` is never high without `decision_valid`;
- copy-all forces acceptance, and with every enable off the frame is refused;
- the flag tracks the first byte of a frame.

The fold itself, the table half writes, the enables that depend on the group bit, and the snapshot behaviour need known addresses and table contents. Only the bench's scenarios can show them, through hand-derived index values and a per-cycle behavioural model.

// File: rtl/dhf_pkg.sv
package dhf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned TBL_BITS   = 1 << IDX_W;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned TBL_WORDS  = TBL_BITS / WORD_W;

  // Contribution of one address byte, taken at byte position pos, to the index.
  function automatic logic [IDX_W-1:0] fold_byte(input logic [7:0] b, input int unsigned pos);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < 8; i++) begin
      r = r ^ (IDX_W'(b[i]) << ((pos * 8 + i) % IDX_W));
    end
    return r;
  endfunction
endpackage

// File: rtl/dhf_index_accum.sv
module dhf_index_accum
  import dhf_pkg::*;
#(
  parameter int unsigned N_BYTES = ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic [IDX_W-1:0] idx_next,
  output logic             group_now,
  output logic             group_q,
  output logic             last_take
);
  localparam int unsigned CNT_W = $clog2(N_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_base;
  logic             full;
  logic             take;

  assign pos       = frame_start ? '0 : cnt_q;
  assign full      = (cnt_q == CNT_W'(N_BYTES));
  assign take      = byte_valid & (frame_start | ~full);
  assign idx_base  = frame_start ? '0 : idx_q;
  assign idx_next  = take ? (idx_base ^ fold_byte(byte_data, 32'(pos))) : idx_base;
  assign last_take = take & (pos == CNT_W'(N_BYTES - 1));

  always_comb begin
    if (take && pos == '0)   group_now = byte_data[0];
    else if (frame_start)    group_now = 1'b0;
    else                     group_now = group_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      group_q <= 1'b0;
    end else begin
      cnt_q   <= (frame_start ? '0 : cnt_q) + CNT_W'(take);
      idx_q   <= idx_next;
      group_q <= group_now;
    end
  end
endmodule

// File: rtl/dhf_hash_table.sv
module dhf_hash_table
  import dhf_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned WORDS = TBL_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORDS-1:0]   word_we,
  input  logic [W-1:0]       wdata,
  output logic [W*WORDS-1:0] table_q
);
  for (genvar h = 0; h < WORDS; h++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          table_q[h*W +: W] <= '0;
      else if (word_we[h]) table_q[h*W +: W] <= wdata;
    end
  end
endmodule

// File: rtl/dhf_decision.sv
module dhf_decision
  import dhf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                last_take,
  input  logic [IDX_W-1:0]    idx_in,
  input  logic                group_in,
  input  logic [TBL_BITS-1:0] table_in,
  input  logic                ucast_en,
  input  logic                mcast_en,
  input  logic                copy_all,
  output logic                decision_valid,
  output logic                accept
);
  logic lookup_hit;
  logic type_en;
  logic match_now;

  assign lookup_hit = table_in[idx_in];
  assign type_en    = group_in ? mcast_en : ucast_en;
  assign match_now  = copy_all | (lookup_hit & type_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision_valid <= 1'b0;
      accept         <= 1'b0;
    end else if (last_take) begin
      decision_valid <= 1'b1;
      accept         <= match_now;
    end else if (frame_start) begin
      decision_valid <= 1'b0;
      accept         <= 1'b0;
    end
  end
endmodule

// File: rtl/dst_hash_filter.sv
module dst_hash_filter
  import dhf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              tbl_lo_we,
  input  logic              tbl_hi_we,
  input  logic [WORD_W-1:0] tbl_wdata,
  input  logic              ucast_en,
  input  logic              mcast_en,
  input  logic              copy_all,
  output logic              decision_valid,
  output logic              accept,
  output logic              multicast_flag
);
  logic [IDX_W-1:0]    idx_next;
  logic                group_now;
  logic                group_q;
  logic                last_take;
  logic [TBL_BITS-1:0] table_q;

  dhf_index_accum #(.N_BYTES(ADDR_BYTES)) u_accum (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .idx_next(idx_next), .group_now(group_now), .group_q(group_q),
    .last_take(last_take)
  );

  dhf_hash_table #(.W(WORD_W), .WORDS(TBL_WORDS)) u_table (
    .clk(clk), .rst_n(rst_n), .word_we({tbl_hi_we, tbl_lo_we}),
    .wdata(tbl_wdata), .table_q(table_q)
  );

  dhf_decision u_decide (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .last_take(last_take),
    .idx_in(idx_next), .group_in(group_now), .table_in(table_q),
    .ucast_en(ucast_en), .mcast_en(mcast_en), .copy_all(copy_all),
    .decision_valid(decision_valid), .accept(accept)
  );

  assign multicast_flag = group_q;
endmodule

// File: rtl/dhf_checker.sv
module dhf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       ucast_en,
  input logic       mcast_en,
  input logic       copy_all,
  input logic       last_take,
  input logic       decision_valid,
  input logic       accept,
  input logic       multicast_flag
);
  a_r7_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> decision_valid);

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !byte_valid |=> !decision_valid && !accept);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid && !frame_start |=> decision_valid && $stable(accept) && $stable(multicast_flag));

  a_r7_no_accept_early: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> !accept);

  a_r6_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
    last_take && copy_all |=> accept);

  a_r5_all_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    last_take && !copy_all && !ucast_en && !mcast_en |=> !accept);

  a_r9_flag_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && byte_valid |=> multicast_flag == $past(byte_data[0]));
endmodule

bind dst_hash_filter dhf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
  .byte_data(byte_data), .ucast_en(ucast_en), .mcast_en(mcast_en),
  .copy_all(copy_all), .last_take(last_take), .decision_valid(decision_valid),
  .accept(accept), .multicast_flag(multicast_flag)
);

// File: tb/tb_dst_hash_filter.sv
module tb_dst_hash_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        tbl_lo_we = 1'b0, tbl_hi_we = 1'b0;
  logic [31:0] tbl_wdata = '0;
  logic        ucast_en = 1'b0, mcast_en = 1'b0, copy_all = 1'b0;
  logic        decision_valid, accept, multicast_flag;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dst_hash_filter dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .tbl_lo_we(tbl_lo_we), .tbl_hi_we(tbl_hi_we),
    .tbl_wdata(tbl_wdata), .ucast_en(ucast_en), .mcast_en(mcast_en),
    .copy_all(copy_all), .decision_valid(decision_valid), .accept(accept),
    .multicast_flag(multicast_flag)
  );

  // Behavioural reference model
  logic [7:0]  mq[$];
  bit   [63:0] mtab = '0;
  bit          m_dv = 0, m_acc = 0, m_grp = 0;

  function automatic int ref_index();
    int idx = 0;
    for (int j = 0; j < 48; j++)
      if (mq[j/8][j%8]) idx = idx ^ (1 << (j % 6));
    return idx;
  endfunction

  always @(posedge clk) begin
    bit [63:0] old_tab;
    int idx;
    if (!rst_n) begin
      mq.delete(); mtab = '0; m_dv = 0; m_acc = 0; m_grp = 0;
    end else begin
      old_tab = mtab;
      if (frame_start) begin
        mq.delete(); m_dv = 0; m_acc = 0; m_grp = 0;
      end
      if (byte_valid && mq.size() < 6) begin
        mq.push_back(byte_data);
        if (mq.size() == 1) m_grp = byte_data[0];
        if (mq.size() == 6) begin
          idx = ref_index();
          m_dv = 1;
          m_acc = copy_all || (old_tab[idx] && (m_grp ? mcast_en : ucast_en));
        end
      end
      if (tbl_lo_we) mtab[31:0]  = tbl_wdata;
      if (tbl_hi_we) mtab[63:32] = tbl_wdata;
    end
  end

  task automatic compare(input string tag);
    vectors++;
    if (decision_valid !== m_dv || accept !== m_acc || multicast_flag !== m_grp) begin
      misses++;
      $display("FAIL %s model: got dv=%0b acc=%0b mc=%0b expected dv=%0b acc=%0b mc=%0b",
               tag, decision_valid, accept, multicast_flag, m_dv, m_acc, m_grp);
    end
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    frame_start = 0; byte_valid = 0;
    repeat (n) tick(tag);
  endtask

  task automatic wr_tbl(input bit lo, input bit hi, input logic [31:0] d, input string tag);
    tbl_lo_we = lo; tbl_hi_we = hi; tbl_wdata = d;
    tick(tag);
    tbl_lo_we = 0; tbl_hi_we = 0;
  endtask

  // Send a 48-bit address, byte 0 in bits 7:0; optional gaps and a table
  // write of zero to the low word in the cycle of the last byte.
  task automatic send_addr(input logic [47:0] a, input int gap, input bit wr_last, input string tag);
    for (int k = 0; k < 6; k++) begin
      frame_start = (k == 0); byte_valid = 1; byte_data = a[8*k +: 8];
      if (wr_last && k == 5) begin tbl_lo_we = 1; tbl_wdata = '0; end
      tick(tag);
      tbl_lo_we = 0;
      frame_start = 0; byte_valid = 0;
      if (gap > 0 && k < 5) idle(gap, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) tick("R1");
    chk("R1 dv", decision_valid, 0); chk("R1 acc", accept, 0); chk("R1 mc", multicast_flag, 0);
    rst_n = 1;
    idle(2, "R1");
    ucast_en = 1;
    send_addr(48'h7E, 0, 0, "R1");
    chk("R1 empty table rejects", accept, 0);

    // R2 / R5: index 4 from byte1 bit0
    wr_tbl(1, 0, 32'h0000_0010, "R3");
    send_addr(48'h0000_0000_0100, 0, 0, "R2");
    chk("R2 index 4 hit", accept, 1);
    chk("R7 valid", decision_valid, 1);
    send_addr(48'h0, 0, 0, "R5");
    chk("R5 index 0 miss", accept, 0);

    // R3 high word, index 63
    wr_tbl(0, 1, 32'h8000_0000, "R3");
    send_addr(48'h7E, 0, 0, "R2");
    chk("R2 index 63 hit", accept, 1);
    wr_tbl(1, 0, 32'h0, "R3");
    send_addr(48'h7E, 0, 0, "R3");
    chk("R3 high word kept", accept, 1);
    send_addr(48'h0100, 0, 0, "R3");
    chk("R3 low word cleared", accept, 0);

    // R5 unicast enable off
    ucast_en = 0;
    send_addr(48'h7E, 0, 0, "R5");
    chk("R5 disabled", accept, 0);

    // R4 / R11 multicast, all ones
    mcast_en = 1;
    wr_tbl(1, 1, 32'hFFFF_FFFF, "R11");
    send_addr(48'h01, 0, 0, "R11");
    chk("R11 mc accepted", accept, 1);
    chk("R9 flag set", multicast_flag, 1);
    send_addr(48'hAB_CD_EF_12_34_57, 0, 0, "R11");
    chk("R11 mc any", accept, 1);
    send_addr(48'h7E, 0, 0, "R4");
    chk("R4 unicast needs ucast_en", accept, 0);
    chk("R9 flag clear", multicast_flag, 0);

    // R4 specific index 1
    wr_tbl(1, 1, 32'h0, "R4");
    wr_tbl(1, 0, 32'h2, "R4");
    send_addr(48'h01, 0, 0, "R4");
    chk("R4 index 1 hit", accept, 1);
    mcast_en = 0;
    send_addr(48'h01, 0, 0, "R4");
    chk("R4 mcast_en off", accept, 0);

    // R6 copy-all
    wr_tbl(1, 0, 32'h0, "R6");
    copy_all = 1;
    send_addr(48'h1234, 0, 0, "R6");
    chk("R6 copy all", accept, 1);
    copy_all = 0;

    // R7 gaps and trailing bytes
    ucast_en = 1;
    wr_tbl(1, 0, 32'h10, "R7");
    send_addr(48'h0100, 2, 0, "R7");
    chk("R7 gapped frame", accept, 1);
    byte_valid = 1; byte_data = 8'hFF;
    repeat (4) tick("R7");
    byte_valid = 0;
    chk("R7 extra bytes ignored dv", decision_valid, 1);
    chk("R7 extra bytes ignored acc", accept, 1);

    // R8 bare start clears; restart mid-frame
    frame_start = 1; tick("R8"); frame_start = 0;
    chk("R8 cleared dv", decision_valid, 0);
    chk("R8 cleared acc", accept, 0);
    for (int k = 0; k < 3; k++) begin
      frame_start = (k == 0); byte_valid = 1; byte_data = 8'hFF; tick("R8");
    end
    byte_valid = 0; frame_start = 0;
    send_addr(48'h0100, 0, 0, "R8");
    chk("R8 restart", accept, 1);

    // R10 snapshot
    ucast_en = 0; copy_all = 0;
    wr_tbl(1, 1, 32'h0, "R10");
    idle(3, "R10");
    chk("R10 held", accept, 1);

    // R3 write in last-byte cycle
    ucast_en = 1;
    wr_tbl(1, 0, 32'h10, "R3");
    send_addr(48'h0100, 0, 1, "R3");
    chk("R3 old table used", accept, 1);
    send_addr(48'h0100, 0, 0, "R3");
    chk("R3 new table used", accept, 0);

    // Random sweep against the model
    for (int f = 0; f < 400; f++) begin
      logic [47:0] a;
      a = {$urandom(), $urandom()};
      ucast_en = $urandom_range(0, 1);
      mcast_en = $urandom_range(0, 1);
      copy_all = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) wr_tbl($urandom_range(0, 1), $urandom_range(0, 1), $urandom(), "R2");
      send_addr(a, $urandom_range(0, 1), $urandom_range(0, 1), "R2");
      idle($urandom_range(0, 2), "R2");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule